// File: doc/BRIEF.md
# PLL-Lock Startup Sequencer

This block brings a high-speed I/O clocking scheme out of reset in a safe order. An asynchronous external reset is passed on to the PLL. The PLL's lock indication is brought into the divided fabric clock domain through a synchronizer. While the synchronized lock is low, all downstream blocks are held in reset. Once lock is seen, a settling counter runs on the divided clock. Only when that counter has finished is the enable for the fast PHY clock output raised, so the fabric logic is stable before any data reaches the pins.

If lock is lost at any time, the downstream reset comes back at once and the fast-clock enable drops in the same cycle. The settling count then starts again from zero on the next lock. The block also reports the ratio between the I/O clock and the fabric clock. This ratio depends on the serialization factor (4:1 or 8:1) and on whether the high-speed clock comes from the PLL or from an external source or serial mode, where the data rate is twice the source clock. The whole block runs on the divided fabric clock, at up to 200 MHz.

Top module: `pll_startup_seq`

## Requirements
- R1: `pll_rst_out` is high whenever `ext_rst_in` is high and low whenever it is low, with no clock edge needed.
- R2: While `ext_rst_in` is high, `blk_rst_out` is 1 and `phy_clk_en_out` is 0 at once, whatever the state of `pll_locked_in`.
- R3: With reset released and `pll_locked_in` high, `blk_rst_out` falls after the second rising edge of `clk_div` that samples the lock high (two-flop synchronizer).
- R4: `blk_rst_out` is the inverse of the synchronized lock: after `pll_locked_in` goes low, it rises after the second rising edge that samples the lock low.
- R5: With lock held, `phy_clk_en_out` rises exactly `SETTLE_CYCLES` rising edges after the edge at which `blk_rst_out` fell (default 64).
- R6: `phy_clk_en_out` is never 1 while `blk_rst_out` is 1.
- R7: When the synchronized lock drops, `phy_clk_en_out` falls on the same edge at which `blk_rst_out` rises, and the settling state is cleared.
- R8: A lock drop of any length, even one cycle, restarts the settling count. After relock, the full `SETTLE_CYCLES` wait applies again, counted from the new fall of `blk_rst_out`.
- R9: `fab_ratio_out` gives the I/O-to-fabric clock ratio as a binary number. With `src_sel_fast`=0 (PLL source) it is 8 when `ser_sel_8`=1 and 4 when `ser_sel_8`=0. With `src_sel_fast`=1 (external source or serial mode) it is 4 when `ser_sel_8`=1 and 2 when `ser_sel_8`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div | input | 1 | Divided fabric clock from the PLL |
| ext_rst_in | input | 1 | Asynchronous external reset, active high |
| pll_locked_in | input | 1 | PLL lock indication, asynchronous to `clk_div` |
| ser_sel_8 | input | 1 | 1 selects 8:1 serialization, 0 selects 4:1 |
| src_sel_fast | input | 1 | 1 means external clock source or serial mode, 0 means PLL source |
| pll_rst_out | output | 1 | Reset forwarded to the PLL |
| blk_rst_out | output | 1 | Reset for downstream blocks, active high |
| phy_clk_en_out | output | 1 | Enable for the high-speed PHY clock output |
| fab_ratio_out | output | 4 | I/O clock to fabric clock ratio (2, 4 or 8) |

## Verification
The PLL reset and the ratio are combinational, and so is the effect of external reset on the two sequenced outputs. These are checked one time unit after the inputs change. `blk_rst_out` follows the lock with a latency of two rising edges. `phy_clk_en_out` follows the fall of `blk_rst_out` after `SETTLE_CYCLES` more edges. The bench keeps a queue of lock samples taken at each rising edge and a run length of the synchronized lock. It compares both outputs one time unit after every rising edge, while the stimulus changes only on falling edges. A separate counter measures the edges from the fall of the reset to the rise of the enable.

// File: rtl/pll_startup_pkg.sv
package pll_startup_pkg;

  // Ratio of I/O clock to fabric clock, as a binary number.
  // PLL source: ratio equals the serialization factor.
  // External source or serial mode: data rate is twice the source, so ratio halves.
  function automatic logic [3:0] fab_div_ratio(input logic ser8, input logic src_fast);
    logic [1:0] shamt;
    shamt = 2'd2 + {1'b0, ser8} - {1'b0, src_fast};
    return 4'd1 << shamt;
  endfunction

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pss_lock_sync.sv
module pss_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_a,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pss_settle_cnt.sv
module pss_settle_cnt
  import pll_startup_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_a,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = cnt_width(SETTLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/pss_ratio_sel.sv
module pss_ratio_sel
  import pll_startup_pkg::*;
(
  input  logic       ser8_i,
  input  logic       src_fast_i,
  output logic [3:0] ratio_o
);
  always_comb ratio_o = fab_div_ratio(ser8_i, src_fast_i);
endmodule

// File: rtl/pll_startup_seq.sv
module pll_startup_seq #(
  parameter int unsigned SETTLE_CYCLES = 64,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_div,
  input  logic       ext_rst_in,
  input  logic       pll_locked_in,
  input  logic       ser_sel_8,
  input  logic       src_sel_fast,
  output logic       pll_rst_out,
  output logic       blk_rst_out,
  output logic       phy_clk_en_out,
  output logic [3:0] fab_ratio_out
);
  // Internal events, named for the checker.
  logic lock_sync_w;
  logic settle_done_w;

  assign pll_rst_out = ext_rst_in;

  pss_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_div),
    .rst_a   (ext_rst_in),
    .d_async (pll_locked_in),
    .q_sync  (lock_sync_w)
  );

  pss_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_cnt (
    .clk    (clk_div),
    .rst_a  (ext_rst_in),
    .run_i  (lock_sync_w),
    .done_o (settle_done_w)
  );

  pss_ratio_sel u_ratio (
    .ser8_i     (ser_sel_8),
    .src_fast_i (src_sel_fast),
    .ratio_o    (fab_ratio_out)
  );

  assign blk_rst_out    = ~lock_sync_w;
  assign phy_clk_en_out = lock_sync_w & settle_done_w;
endmodule

// File: rtl/pll_startup_seq_chk.sv
module pll_startup_seq_chk
  import pll_startup_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input logic       clk_div,
  input logic       ext_rst_in,
  input logic       pll_locked_in,
  input logic       blk_rst_out,
  input logic       phy_clk_en_out,
  input logic [3:0] fab_ratio_out,
  input logic       lock_sync_w,
  input logic       settle_done_w
);
  localparam int unsigned CW = cnt_width(SETTLE_CYCLES + 2);

  logic [CW-1:0] since_rel_q;

  always_ff @(posedge clk_div or posedge ext_rst_in) begin
    if (ext_rst_in)                        since_rel_q <= '0;
    else if (blk_rst_out)                  since_rel_q <= '0;
    else if (since_rel_q != CW'(SETTLE_CYCLES + 1)) since_rel_q <= since_rel_q + 1'b1;
  end

  a_r3_release_after_sync: assert property (@(posedge clk_div) disable iff (ext_rst_in)
    $fell(blk_rst_out) |-> $past(pll_locked_in, 2));

  a_r4_reset_after_sync: assert property (@(posedge clk_div) disable iff (ext_rst_in)
    $rose(blk_rst_out) |-> !$past(pll_locked_in, 2));

  a_r5_settle_window: assert property (@(posedge clk_div) disable iff (ext_rst_in)
    $rose(phy_clk_en_out) |-> (since_rel_q == CW'(SETTLE_CYCLES)));

  a_r6_no_en_in_reset: assert property (@(posedge clk_div) disable iff (ext_rst_in)
    phy_clk_en_out |-> !blk_rst_out);

  a_r7_settle_cleared: assert property (@(posedge clk_div) disable iff (ext_rst_in)
    $fell(lock_sync_w) |=> !settle_done_w);

  a_r9_ratio_legal: assert property (@(posedge clk_div) disable iff (ext_rst_in)
    ($countones(fab_ratio_out) == 1) && !fab_ratio_out[0]);
endmodule

bind pll_startup_seq pll_startup_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk_div        (clk_div),
  .ext_rst_in     (ext_rst_in),
  .pll_locked_in  (pll_locked_in),
  .blk_rst_out    (blk_rst_out),
  .phy_clk_en_out (phy_clk_en_out),
  .fab_ratio_out  (fab_ratio_out),
  .lock_sync_w    (lock_sync_w),
  .settle_done_w  (settle_done_w)
);

// File: tb/pll_startup_seq_tb.sv
module pll_startup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 64;
  localparam int WATCHDOG   = 150000;

  logic       clk_div = 1'b0;
  logic       ext_rst_in = 1'b1;
  logic       pll_locked_in = 1'b1;
  logic       ser_sel_8 = 1'b1;
  logic       src_sel_fast = 1'b0;
  logic       pll_rst_out, blk_rst_out, phy_clk_en_out;
  logic [3:0] fab_ratio_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  pll_startup_seq #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk_div        (clk_div),
    .ext_rst_in     (ext_rst_in),
    .pll_locked_in  (pll_locked_in),
    .ser_sel_8      (ser_sel_8),
    .src_sel_fast   (src_sel_fast),
    .pll_rst_out    (pll_rst_out),
    .blk_rst_out    (blk_rst_out),
    .phy_clk_en_out (phy_clk_en_out),
    .fab_ratio_out  (fab_ratio_out)
  );

  always #(CLK_PERIOD/2) clk_div = ~clk_div;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: queue of lock samples and run length of synchronized lock.
  int hist[$];
  int run = 0;
  int exp_lock = 0;
  int since_rel = -1;
  int prev_en = 0;
  int prev_blk = 1;
  int cycles = 0;

  always begin
    @(posedge clk_div);
    cycles++;
    if (ext_rst_in) begin
      hist.delete();
      run = 0;
      exp_lock = 0;
    end else begin
      hist.push_back(int'(pll_locked_in));
      exp_lock = (hist.size() >= 2) ? hist[hist.size()-2] : 0;
      run = exp_lock ? run + 1 : 0;
    end
    #1;
    // R3 R4: downstream reset is inverse of two-flop synchronized lock
    check("R3 R4 blk_rst_out", int'(blk_rst_out), exp_lock ? 0 : 1);
    // R5 R7 R8: enable needs SETTLE edges of unbroken synchronized lock
    check("R5 R7 R8 phy_clk_en_out", int'(phy_clk_en_out), (run > SETTLE) ? 1 : 0);
    // R6
    check("R6 no enable under reset", int'(phy_clk_en_out && blk_rst_out), 0);
    if (prev_blk == 1 && blk_rst_out == 0) since_rel = 0;
    else if (since_rel >= 0) since_rel++;
    if (blk_rst_out) since_rel = -1;
    if (prev_en == 0 && phy_clk_en_out == 1) check("R5 settle edges", since_rel, SETTLE);
    prev_en = int'(phy_clk_en_out);
    prev_blk = int'(blk_rst_out);
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_div);
  endtask

  function automatic int ratio_ref(input bit s8, input bit fast);
    case ({s8, fast})
      2'b10:   return 8;
      2'b00:   return 4;
      2'b11:   return 4;
      default: return 2;
    endcase
  endfunction

  initial begin
    // R1 R2: reset state with lock already high
    #1;
    check("R1 pll_rst_out in reset", int'(pll_rst_out), 1);
    check("R2 blk_rst_out in reset", int'(blk_rst_out), 1);
    check("R2 phy_clk_en_out in reset", int'(phy_clk_en_out), 0);
    wait_neg(3);
    ext_rst_in = 1'b0;
    #1 check("R1 pll_rst_out released", int'(pll_rst_out), 0);
    wait_neg(SETTLE + 10);
    check("R5 enabled after settle", int'(phy_clk_en_out), 1);
    // R8: one-cycle lock glitch
    pll_locked_in = 1'b0;
    wait_neg(1);
    pll_locked_in = 1'b1;
    wait_neg(4);
    check("R8 enable off after glitch", int'(phy_clk_en_out), 0);
    wait_neg(SETTLE + 5);
    // R7: longer loss
    pll_locked_in = 1'b0;
    wait_neg(5);
    check("R4 R7 reset back", int'(blk_rst_out), 1);
    pll_locked_in = 1'b1;
    wait_neg(30);
    // R8: loss during settling
    pll_locked_in = 1'b0;
    wait_neg(2);
    pll_locked_in = 1'b1;
    wait_neg(SETTLE + 8);
    // R2: asynchronous external reset mid-operation
    ext_rst_in = 1'b1;
    #1;
    check("R1 pll_rst_out async", int'(pll_rst_out), 1);
    check("R2 blk_rst_out async", int'(blk_rst_out), 1);
    check("R2 phy_clk_en_out async", int'(phy_clk_en_out), 0);
    wait_neg(3);
    pll_locked_in = 1'b0;
    ext_rst_in = 1'b0;
    wait_neg(6);
    check("R3 held without lock", int'(blk_rst_out), 1);
    pll_locked_in = 1'b1;
    wait_neg(SETTLE + 6);
    // R9: all ratio selections
    for (int k = 0; k < 4; k++) begin
      ser_sel_8 = k[1];
      src_sel_fast = k[0];
      #1 check("R9 fab_ratio_out", int'(fab_ratio_out), ratio_ref(k[1], k[0]));
      wait_neg(1);
    end
    wait_neg(2);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule